// File: doc/BRIEF.md
# Run-Time Programmable RAM Delay Line

The block delays a data stream by a number of cycles chosen at run time. Every enabled cycle it writes the incoming word into a simple dual-port RAM at a free-running write position. It reads the RAM at that position minus the requested delay. The word read out passes through a short output pipeline. The delay input may change on any cycle. The block then jumps straight to the new read position, so words in the output stream are repeated or skipped.

The total latency from `din` to `dout` is the requested delay plus `RD_LAT` cycles. `RD_LAT` covers three stages:
- the registered read address;
- the RAM output register;
- `RD_LAT-2` further pipeline registers, which help timing.

A parameter selects whether the `en` input is used. When it is used and `en` is low, every stage holds its state. All latencies are then counted in enabled cycles.

Top module: `prog_ram_delay`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `dout` reads zero from the next cycle on, and the write position returns to zero.
- R2: With `delay` held at a value d, `dout` in cycle m equals `din` from cycle m-RD_LAT-d, for every sample written since reset.
- R3: A delay of zero is valid and gives a latency of exactly `RD_LAT` cycles.
- R4: The largest delay, 2^MAX_DELAY-1, returns the correct sample even though its RAM entry is rewritten in the same cycle it is read. Read-during-write returns the old word.
- R5: The `delay` value present in cycle c alone selects the word shown in cycle c+RD_LAT: `dout`(c+RD_LAT) = `din`(c-`delay`(c)). No smoothing is applied, so a change repeats or drops words.
- R6: With `USE_EN`=1, an edge at which `en` is low advances nothing. `dout` and the write position hold, and all timing in R2-R5 counts enabled cycles only.
- R7: With `USE_EN`=0, `en` has no effect and the block advances on every cycle.
- R8: The write position advances by one per enabled cycle and wraps modulo 2^MAX_DELAY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; used only when USE_EN=1 |
| din | input | DATA_W | Data word to be delayed |
| delay | input | MAX_DELAY | Requested delay in cycles, 0 to 2^MAX_DELAY-1 |
| dout | output | DATA_W | Delayed data word |

## Verification
The bench keeps a history of every enabled input word and every delay value. From that history it predicts each output word from the R5 relation, even on cycles where the delay jumps.

Several defects would show up as wrong words:
- A read address that is not registered, or a read pipeline one stage short or long, shifts every word by one cycle.
- A RAM that returns new data on a collision corrupts the maximum delay.
- An enable that misses a stage puts the words out of order after a stall.

A second instance with the enable ignored sees the same stalls on `en` and must keep streaming.

// File: rtl/prd_pkg.sv
package prd_pkg;

   // Stages ahead of the extra output pipeline: address register and RAM output register.
   localparam int unsigned FIXED_STAGES = 2;
   // Largest address width accepted, which keeps the RAM to a sane size.
   localparam int unsigned MAX_ADDR_W   = 16;

   // Number of extra output registers for a given total read latency.
   function automatic int unsigned extra_stages(input int unsigned rd_lat);
      return (rd_lat < FIXED_STAGES) ? 0 : rd_lat - FIXED_STAGES;
   endfunction

endpackage

// File: rtl/prd_wr_ptr.sv
module prd_wr_ptr #(
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [AW-1:0] ptr
);

   // Free-running write position; it wraps at 2^AW.
   always_ff @(posedge clk) begin
      if (rst)
         ptr <= '0;
      else if (adv)
         ptr <= AW'(ptr + 1'b1);
   end

endmodule

// File: rtl/prd_rd_addr.sv
module prd_rd_addr #(
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic [AW-1:0] wr_ptr,
   input  logic [AW-1:0] delay,
   output logic [AW-1:0] rd_addr
);

   logic [AW-1:0] diff;

   // Modulo subtraction; the wrap of the ring is free in AW bits.
   assign diff = AW'(wr_ptr - delay);

   // The address is registered, so a delay of zero reads the word
   // written in the same cycle once the RAM sees it.
   always_ff @(posedge clk) begin
      if (rst)
         rd_addr <= '0;
      else if (adv)
         rd_addr <= diff;
   end

endmodule

// File: rtl/prd_sdp_ram.sv
module prd_sdp_ram #(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   // Write port; the array itself is not reset.
   always_ff @(posedge clk) begin
      if (adv)
         mem[wr_addr] <= wr_data;
   end

   // Registered read port. On an address collision it returns the old word.
   always_ff @(posedge clk) begin
      if (rst)
         rd_data <= '0;
      else if (adv)
         rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/prd_pipe.sv
module prd_pipe #(
   parameter int unsigned DW     = 16,
   parameter int unsigned STAGES = 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   generate
      if (STAGES == 0) begin : g_thru
         logic unused_ctl;
         assign unused_ctl = clk ^ rst ^ adv;
         assign q = d;
      end else begin : g_regs
         for (genvar s = 0; s < STAGES; s++) begin : g_stg
            logic [DW-1:0] r;
            logic [DW-1:0] nxt;
            if (s == 0) begin : g_first
               assign nxt = d;
            end else begin : g_next
               assign nxt = g_stg[s-1].r;
            end
            always_ff @(posedge clk) begin
               if (rst)
                  r <= '0;
               else if (adv)
                  r <= nxt;
            end
         end
         assign q = g_stg[STAGES-1].r;
      end
   endgenerate

endmodule

// File: rtl/prog_ram_delay.sv
module prog_ram_delay #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned MAX_DELAY = 7,
   parameter int unsigned RD_LAT    = 5,
   parameter bit          USE_EN    = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 en,
   input  logic [DATA_W-1:0]    din,
   input  logic [MAX_DELAY-1:0] delay,
   output logic [DATA_W-1:0]    dout
);

   localparam int unsigned PIPE_STAGES = prd_pkg::extra_stages(RD_LAT);

   // Parameter checks at elaboration time.
   if (RD_LAT < prd_pkg::FIXED_STAGES) begin : g_bad_lat
      $error("prog_ram_delay: RD_LAT must be at least %0d", prd_pkg::FIXED_STAGES);
   end
   if (MAX_DELAY < 1 || MAX_DELAY > prd_pkg::MAX_ADDR_W) begin : g_bad_aw
      $error("prog_ram_delay: MAX_DELAY must lie in 1..%0d", prd_pkg::MAX_ADDR_W);
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("prog_ram_delay: DATA_W must be at least 1");
   end

   logic                 adv;
   logic [MAX_DELAY-1:0] wr_ptr;
   logic [MAX_DELAY-1:0] rd_addr;
   logic [DATA_W-1:0]    ram_q;

   // Choose the advance source.
   generate
      if (USE_EN) begin : g_en
         assign adv = en;
      end else begin : g_free
         logic unused_en;
         assign unused_en = en;
         assign adv = 1'b1;
      end
   endgenerate

   prd_wr_ptr #(
      .AW (MAX_DELAY)
   ) u_wr_ptr (
      .clk (clk),
      .rst (rst),
      .adv (adv),
      .ptr (wr_ptr)
   );

   prd_rd_addr #(
      .AW (MAX_DELAY)
   ) u_rd_addr (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .wr_ptr  (wr_ptr),
      .delay   (delay),
      .rd_addr (rd_addr)
   );

   prd_sdp_ram #(
      .DW (DATA_W),
      .AW (MAX_DELAY)
   ) u_ram (
      .clk     (clk),
      .rst     (rst),
      .adv     (adv),
      .wr_addr (wr_ptr),
      .wr_data (din),
      .rd_addr (rd_addr),
      .rd_data (ram_q)
   );

   prd_pipe #(
      .DW     (DATA_W),
      .STAGES (PIPE_STAGES)
   ) u_pipe (
      .clk (clk),
      .rst (rst),
      .adv (adv),
      .d   (ram_q),
      .q   (dout)
   );

endmodule

// File: rtl/prd_checks.sv
module prd_checks #(
   parameter int unsigned AW = 7,
   parameter int unsigned DW = 16
) (
   input logic          clk,
   input logic          rst,
   input logic          adv,
   input logic [AW-1:0] wr_ptr,
   input logic [AW-1:0] rd_addr,
   input logic [AW-1:0] delay,
   input logic [DW-1:0] dout
);

   logic rst_q  = 1'b0;
   logic seen_q = 1'b0;

   always_ff @(posedge clk) begin
      rst_q  <= rst;
      seen_q <= 1'b1;
   end

   // R1: a reset sampled at the previous edge leaves dout at zero and the pointer at zero.
   always_ff @(posedge clk) begin
      if (seen_q && rst_q) begin
         assert_reset_dout_R1: assert (dout == '0)
            else $error("dout not cleared by reset");
         assert_reset_ptr_R1: assert (wr_ptr == '0)
            else $error("write pointer not cleared by reset");
      end
   end

   // R8: one step per enabled cycle, wrapping modulo 2^AW.
   assert_ptr_step_R8: assert property (@(posedge clk) disable iff (rst)
      adv |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));

   // R6: a stalled edge changes neither the pointer nor the output.
   assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !adv |=> ($stable(wr_ptr) && $stable(dout)));

   // R5: the read address follows the delay present one enabled cycle earlier.
   assert_addr_follow_R5: assert property (@(posedge clk) disable iff (rst)
      adv |=> rd_addr == AW'($past(wr_ptr) - $past(delay)));

   // R6: a stalled edge also freezes the read address.
   assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(rd_addr));

endmodule

bind prog_ram_delay prd_checks #(
   .AW (MAX_DELAY),
   .DW (DATA_W)
) u_prd_checks (
   .clk     (clk),
   .rst     (rst),
   .adv     (adv),
   .wr_ptr  (wr_ptr),
   .rd_addr (rd_addr),
   .delay   (delay),
   .dout    (dout)
);

// File: tb/prog_ram_delay_tb_top.sv
module prog_ram_delay_tb_top;

   localparam int DW   = 16;
   localparam int MD   = 7;
   localparam int LAT  = 5;
   localparam int N    = 1 << MD;
   localparam int HMAX = 8192;

   logic          clk   = 1'b0;
   logic          rst   = 1'b1;
   logic          en    = 1'b1;
   logic [DW-1:0] din   = '0;
   logic [MD-1:0] delay = '0;
   logic [DW-1:0] dout_a;
   logic [DW-1:0] dout_b;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   prog_ram_delay #(.DATA_W(DW), .MAX_DELAY(MD), .RD_LAT(LAT), .USE_EN(1'b1)) dut_i (
      .clk(clk), .rst(rst), .en(en), .din(din), .delay(delay), .dout(dout_a));

   prog_ram_delay #(.DATA_W(DW), .MAX_DELAY(MD), .RD_LAT(LAT), .USE_EN(1'b0)) dut_ne_i (
      .clk(clk), .rst(rst), .en(en), .din(din), .delay(delay), .dout(dout_b));

   // Input history, one entry per advancing edge of each instance.
   logic [DW-1:0] ha_din [HMAX];
   int            ha_dly [HMAX];
   int            na = 0;
   logic [DW-1:0] hb_din [HMAX];
   int            hb_dly [HMAX];
   int            nb = 0;

   always @(posedge clk) begin
      if (rst) begin
         na <= 0;
         nb <= 0;
      end else begin
         if (en && na < HMAX) begin
            ha_din[na] <= din;
            ha_dly[na] <= int'(delay);
            na <= na + 1;
         end
         if (nb < HMAX) begin
            hb_din[nb] <= din;
            hb_dly[nb] <= int'(delay);
            nb <= nb + 1;
         end
      end
   end

   // dout after the latest edge: the read address was formed LAT-1 edges earlier.
   function automatic bit exp_a(output logic [DW-1:0] e);
      int j = na - LAT;
      int s;
      e = '0;
      if (j < 0) return 1'b0;
      s = j - ha_dly[j];
      if (s < 0) return 1'b0;
      e = ha_din[s];
      return 1'b1;
   endfunction

   function automatic bit exp_b(output logic [DW-1:0] e);
      int j = nb - LAT;
      int s;
      e = '0;
      if (j < 0) return 1'b0;
      s = j - hb_dly[j];
      if (s < 0) return 1'b0;
      e = hb_din[s];
      return 1'b1;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: dout=%h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   // Wait for the next falling edge, then compare both instances with the model.
   task automatic step(input string tag_a, input string tag_b);
      logic [DW-1:0] e;
      @(negedge clk);
      if (exp_a(e)) check(tag_a, dout_a, e);
      if (exp_b(e)) check(tag_b, dout_b, e);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      en  = 1'b1;
      din = $urandom;
      repeat (3) begin
         @(negedge clk);
         check("R1 reset A", dout_a, '0);
         check("R1 reset B", dout_b, '0);
      end
      rst = 1'b0;
   endtask

   task automatic t_fixed(input int d, input int cycles, input string tag);
      delay = MD'(d);
      en    = 1'b1;
      repeat (cycles) begin
         din = $urandom;
         step(tag, tag);
      end
   endtask

   task automatic t_change();
      en = 1'b1;
      for (int seg = 0; seg < 40; seg++) begin
         delay = MD'($urandom);
         for (int k = 0; k < 1 + int'($urandom % 12); k++) begin
            din = $urandom;
            step("R5 delay change", "R5 delay change");
         end
      end
      // Single-cycle excursions between neighbouring delays.
      for (int k = 0; k < 30; k++) begin
         delay = MD'((k % 2 == 0) ? 20 : 23);
         din = $urandom;
         step("R5 toggle", "R5 toggle");
      end
   endtask

   task automatic t_enable();
      logic [DW-1:0] last_a;
      bit            was_en;
      delay  = MD'(9);
      last_a = dout_a;
      for (int k = 0; k < 300; k++) begin
         was_en = ($urandom % 100) < 60;
         en  = was_en;
         din = $urandom;
         step("R6 gated", "R7 enable ignored");
         if (!was_en) check("R6 hold", dout_a, last_a);
         last_a = dout_a;
      end
      en = 1'b1;
   endtask

   initial begin
      t_reset();
      t_fixed(5, 200, "R2 delay 5");
      t_fixed(37, 150, "R2 delay 37");
      t_fixed(0, 60, "R3 delay zero");
      t_fixed(N - 1, 2 * N + 20, "R4 R8 max delay");
      t_change();
      t_enable();
      t_reset();
      t_fixed(3, 60, "R2 after reset");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all requirements): run still active after %0d cycles, expected end earlier", 200000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule